// File: doc/BRIEF.md
# Branch Resolution and Fetch Redirect Unit

This unit sits beside the decode stage of a five-stage integer pipeline. It decides the fate of control-transfer instructions: conditional branches on zero or nonzero, register-indirect jumps, region-relative direct jumps and the trap that ends a program. For each valid instruction it produces the next fetch address and a load strobe for the program counter. It also drives a fetch-freeze line and a line that turns the following instruction into an idle bubble.

A static two-bit policy input selects one of four ways of handling branches: 00 freeze, 01 predict-taken, 10 predict-not-taken, 11 delayed slot. Each policy has its own rule for correcting the target and for freezing and squashing. A trap raises a sticky halt flag that only reset clears. Once halted, the unit ignores every further instruction.

Top module: `branch_resolver`

## Requirements
- R1: Opcode class encoding is 1 BEQZ, 2 BNEZ, 3 JR, 4 J, 5 TRAP. BEQZ is taken when the source value is zero and BNEZ when it is nonzero. A taken branch raises pc_load. An untaken branch leaves pc_load low and next_pc equal to the incremented PC.
- R2: A taken conditional branch targets the incremented PC plus the immediate. Under policies 10 and 11, 4 is subtracted from that sum.
- R3: A valid JR raises pc_load, with next_pc equal to the source value.
- R4: A valid J raises pc_load. Its target keeps the top 4 bits of the current PC and adds the 26-bit offset shifted left by 2.
- R5: A valid J raises fetch_freeze in its cycle only under policies 00 and 01. Under policies 10 and 11 no freeze occurs.
- R6: squash_next is raised only under policy 10, for a taken conditional branch, a JR or a J. Under the other policies it stays low, including the delayed-slot policy 11.
- R7: A valid TRAP raises fetch_freeze in its cycle. halted rises on the next clock and then stays high, with fetch_freeze high. From then on pc_load and squash_next stay low whatever arrives.
- R8: While reset is held, and on leaving reset, halted is low.
- R9: When valid is low, or the class is not a control transfer, pc_load, fetch_freeze and squash_next are low and next_pc equals the incremented PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | Static branch-handling policy |
| valid | input | 1 | An instruction is present for resolution |
| op | input | 3 | Decoded control-transfer class |
| src_val | input | AW | Source register value |
| imm | input | AW | Sign-extended immediate |
| jofs | input | OFS_W | Direct jump offset field |
| pc_inc | input | AW | Incremented PC of the instruction |
| pc_cur | input | AW | Current PC |
| next_pc | output | AW | Next fetch address |
| pc_load | output | 1 | Load next_pc as a redirect |
| fetch_freeze | output | 1 | Hold fetch this cycle |
| squash_next | output | 1 | Turn the following instruction into a bubble |
| halted | output | 1 | Program complete, fetch stopped |

## Verification
The embedded properties check a set of conditions on every clock. The halt flag never drops outside reset. A halted unit never loads the PC or squashes. The delayed-slot policy never squashes and freezes only for a trap. A direct jump target always keeps the current region bits. The arithmetic of each target, the match between policy and freeze or squash behaviour, and the untaken cases can only be shown by the bench. It compares every output against an independent model across random mixes of policy, opcode and operand values. It also runs directed cases: zero and nonzero sources, negative immediates, jumps from high regions, and a trap followed by further instructions and a reset.

// File: rtl/branch_resolver.sv
module branch_resolver #(
  parameter int AW    = 32,
  parameter int OFS_W = 26,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       policy,
  input  logic             valid,
  input  logic [2:0]       op,
  input  logic [AW-1:0]    src_val,
  input  logic [AW-1:0]    imm,
  input  logic [OFS_W-1:0] jofs,
  input  logic [AW-1:0]    pc_inc,
  input  logic [AW-1:0]    pc_cur,
  output logic [AW-1:0]    next_pc,
  output logic             pc_load,
  output logic             fetch_freeze,
  output logic             squash_next,
  output logic             halted
);
  localparam int SHIFT = $clog2(STEP);
  localparam int LOW   = OFS_W + SHIFT;
  localparam logic [AW-1:0] REGION = {{(AW-LOW){1'b1}}, {LOW{1'b0}}};
  localparam logic [2:0] OP_BEQZ = 3'd1, OP_BNEZ = 3'd2, OP_JR = 3'd3,
                         OP_J = 3'd4, OP_TRAP = 3'd5;

  logic active, is_beqz, is_bnez, is_jr, is_j, is_trap, taken, late_fix;
  logic [AW-1:0] cond_tgt, jump_tgt;

  assign active   = valid & ~halted;
  assign is_beqz  = active & (op == OP_BEQZ);
  assign is_bnez  = active & (op == OP_BNEZ);
  assign is_jr    = active & (op == OP_JR);
  assign is_j     = active & (op == OP_J);
  assign is_trap  = active & (op == OP_TRAP);
  assign taken    = (is_beqz & (src_val == '0)) | (is_bnez & (src_val != '0));
  assign late_fix = policy[1];

  assign cond_tgt = pc_inc + imm - (late_fix ? AW'(STEP) : '0);
  assign jump_tgt = (pc_cur & REGION) + (AW'(jofs) << SHIFT);

  always_comb begin
    next_pc = pc_inc;
    if (taken)      next_pc = cond_tgt;
    else if (is_jr) next_pc = src_val;
    else if (is_j)  next_pc = jump_tgt;
  end

  assign pc_load      = taken | is_jr | is_j;
  assign fetch_freeze = halted | is_trap | (is_j & ~policy[1]);
  assign squash_next  = (policy == 2'b10) & (taken | is_jr | is_j);

  always_ff @(posedge clk) begin
    if (!rst_n) halted <= 1'b0;
    else        halted <= halted | is_trap;
  end

  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!pc_load && !squash_next && fetch_freeze));
  assert_delayed_no_squash_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == 2'b11) |-> !squash_next);
  assert_delayed_no_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == 2'b11 && !halted && !(valid && op == OP_TRAP)) |-> !fetch_freeze);
  assert_jump_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !halted && op == OP_J) |-> (pc_load && next_pc[AW-1:LOW] == pc_cur[AW-1:LOW]));
endmodule

// File: tb/branch_resolver_tb.sv
module branch_resolver_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int OFS_W = 26;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] policy = 2'b00;
  logic valid = 1'b0;
  logic [2:0] op = 3'd0;
  logic [AW-1:0] src_val = '0, imm = '0, pc_inc = '0, pc_cur = '0;
  logic [OFS_W-1:0] jofs = '0;
  logic [AW-1:0] next_pc;
  logic pc_load, fetch_freeze, squash_next, halted;

  int checks = 0, errors = 0;
  logic mh = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_resolver u_dut (.clk(clk), .rst_n(rst_n), .policy(policy), .valid(valid), .op(op),
    .src_val(src_val), .imm(imm), .jofs(jofs), .pc_inc(pc_inc), .pc_cur(pc_cur),
    .next_pc(next_pc), .pc_load(pc_load), .fetch_freeze(fetch_freeze),
    .squash_next(squash_next), .halted(halted));

  function automatic logic [AW+2:0] model(logic [1:0] pol, logic v, logic [2:0] o,
      logic [AW-1:0] s, logic [AW-1:0] im, logic [OFS_W-1:0] jo,
      logic [AW-1:0] pi, logic [AW-1:0] pc, logic h);
    logic [AW-1:0] n; logic ld, fz, sq, tk;
    n = pi; ld = 0; fz = h; sq = 0;
    if (v && !h) begin
      tk = (o == 3'd1 && s == 0) || (o == 3'd2 && s != 0);
      if (tk) begin
        n = pi + im; if (pol >= 2) n = n - 4;
        ld = 1; sq = (pol == 2);
      end else if (o == 3'd3) begin
        n = s; ld = 1; sq = (pol == 2);
      end else if (o == 3'd4) begin
        n = {pc[31:28], jo, 2'b00}; ld = 1; sq = (pol == 2); fz = (pol < 2);
      end else if (o == 3'd5) fz = 1;
    end
    return {n, ld, fz, sq};
  endfunction

  function automatic string tag(logic v, logic [2:0] o, logic h, logic [1:0] pol);
    if (h) return "R7";
    if (!v || o == 0 || o > 5) return "R9";
    if (o == 3'd5) return "R7";
    if (o == 3'd3) return (pol == 2) ? "R6" : "R3";
    if (o == 3'd4) return (pol == 2) ? "R6" : ((pol < 2) ? "R5" : "R4");
    return (pol == 2) ? "R6" : "R2";
  endfunction

  task automatic step(logic [1:0] pol, logic v, logic [2:0] o, logic [AW-1:0] s,
      logic [AW-1:0] im, logic [OFS_W-1:0] jo, logic [AW-1:0] pi, logic [AW-1:0] pc, string t);
    logic [AW+2:0] exp, act;
    @(negedge clk);
    policy = pol; valid = v; op = o; src_val = s; imm = im; jofs = jo; pc_inc = pi; pc_cur = pc;
    #1;
    exp = model(pol, v, o, s, im, jo, pi, pc, mh);
    act = {next_pc, pc_load, fetch_freeze, squash_next};
    if (t == "") t = tag(v, o, mh, pol);
    checks++;
    if (act !== exp || halted !== mh) begin
      errors++;
      $display("FAIL %s: actual pc=%h ld=%b frz=%b sq=%b halt=%b expected pc=%h ld=%b frz=%b sq=%b halt=%b",
        t, act[AW+2:3], act[2], act[1], act[0], halted, exp[AW+2:3], exp[2], exp[1], exp[0], mh);
    end
    if (v && !mh && o == 3'd5) mh = 1'b1;
  endtask

  task automatic check_halt(logic e, string t);
    @(negedge clk); #1;
    checks++;
    if (halted !== e) begin
      errors++;
      $display("FAIL %s: actual halted=%b expected %b", t, halted, e);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed = 12345;
    void'($urandom(seed));
    check_halt(1'b0, "R8");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check_halt(1'b0, "R8");
    // directed corners
    step(2'b00, 1, 3'd1, 0, 32'h10, 0, 32'h100, 32'h0FC, "R1");
    step(2'b00, 1, 3'd1, 5, 32'h10, 0, 32'h100, 32'h0FC, "R1");
    step(2'b01, 1, 3'd2, 0, 32'h10, 0, 32'h100, 32'h0FC, "R1");
    step(2'b10, 1, 3'd2, 7, 32'hFFFF_FFF0, 0, 32'h200, 32'h1FC, "R2");
    step(2'b11, 1, 3'd1, 0, 32'h40, 0, 32'h200, 32'h1FC, "R2");
    step(2'b11, 1, 3'd3, 32'hDEAD_BEE0, 0, 0, 32'h300, 32'h2FC, "R3");
    step(2'b01, 1, 3'd4, 0, 0, 26'h3FF_FFFF, 32'hA000_0004, 32'hA000_0000, "R4");
    step(2'b00, 1, 3'd4, 0, 0, 26'h1, 32'hF000_0004, 32'hF000_0000, "R5");
    step(2'b11, 1, 3'd4, 0, 0, 26'h2, 32'h5000_0004, 32'h5000_0000, "R5");
    step(2'b10, 1, 3'd4, 0, 0, 26'h2, 32'h5000_0004, 32'h5000_0000, "R6");
    step(2'b11, 1, 3'd2, 1, 32'h8, 0, 32'h100, 32'h0FC, "R6");
    step(2'b10, 0, 3'd3, 32'h44, 0, 0, 32'h500, 32'h4FC, "R9");
    step(2'b10, 1, 3'd0, 32'h44, 0, 0, 32'h500, 32'h4FC, "R9");
    step(2'b10, 1, 3'd7, 32'h44, 0, 0, 32'h500, 32'h4FC, "R9");
    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic [AW-1:0] s;
      s = ($urandom % 3 == 0) ? '0 : $urandom;
      step(2'($urandom), ($urandom % 8) != 0, 3'($urandom % 5), s, $urandom,
           26'($urandom), $urandom, $urandom, "");
    end
    // trap and after
    step(2'b11, 1, 3'd5, 0, 0, 0, 32'h600, 32'h5FC, "R7");
    step(2'b10, 1, 3'd4, 0, 0, 26'h5, 32'h604, 32'h600, "R7");
    step(2'b10, 1, 3'd1, 0, 32'h20, 0, 32'h608, 32'h604, "R7");
    for (int i = 0; i < 50; i++)
      step(2'($urandom), 1'b1, 3'($urandom % 6), $urandom, $urandom, 26'($urandom),
           $urandom, $urandom, "R7");
    @(negedge clk); rst_n = 1'b0; valid = 1'b0;
    check_halt(1'b0, "R8");
    rst_n = 1'b1; mh = 1'b0;
    step(2'b10, 1, 3'd3, 32'h1234, 0, 0, 32'h700, 32'h6FC, "R8");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule